// File: doc/BRIEF.md
# Serial Quad DAC Command Receiver

This block is the receive side of a three-wire serial command interface for a four-channel, 8-bit digital-to-analog converter. It watches a serial clock, a serial data line, a word-strobe line and an update-strobe line, all already synchronised into a faster system clock, and finds their falling edges by comparing each line with its value one system clock earlier. Each falling edge of the serial clock shifts one data bit into an 11-bit command word that carries a channel number, a gain bit and an 8-bit code.

A falling edge on the word strobe writes a complete word into the staging register of the channel it names. A word of the wrong length is thrown away and flagged with a one-cycle error pulse. A falling edge on the update strobe copies all four staging registers into the output registers at once, so that all channels can change together. The outputs are the four codes and the four gain flags, ready for the converter core.

Top module: `qdac_serial_rx`

## Requirements
- R1: Each falling edge of `ser_clk_i` (the input was 1 in the previous system clock and is 0 now) shifts the current `ser_dat_i` into the command word, most significant bit first; the shift and the bit count take effect at that system-clock edge.
- R2: The command word is 11 bits. Word bits 10:9 (the first two received) give the channel, 00 to 11 for channels 0 to 3; word bit 8 is the gain bit (0 = x1, 1 = x2); word bits 7:0 are the unsigned code.
- R3: A falling edge of `ser_ld_i` after exactly 11 bits writes the code and gain into the staging register of the selected channel only; the other three staging registers keep their contents, and `frame_err_o` stays low.
- R4: A falling edge of `ser_ld_i` after any bit count other than 11 (fewer or more) writes nothing and drives `frame_err_o` high for exactly one system clock, in the cycle after that edge.
- R5: The bit count returns to zero on every falling edge of `ser_ld_i`. A serial-clock falling edge in the same system clock as a word-strobe falling edge is not counted or shifted.
- R6: A falling edge of `ser_upd_i` copies all four staging registers (code and gain) into the output registers in one system clock; the outputs change at no other time except reset.
- R7: When the word strobe and the update strobe fall in the same system clock, the outputs take the staging contents from before that cycle's write; the new word reaches the outputs at the next update edge.
- R8: While `rst_n` is low, all staging and output registers, the bit count, the command word and the error flag are zero, and the edge detectors hold no edge.
- R9: Channel k's code appears on `dac_code_o[8k+7:8k]` and its gain flag on `dac_gain_o[k]`, with 1 meaning gain x2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Synchronised serial clock; bits are taken on its falling edge |
| ser_dat_i | input | 1 | Synchronised serial data |
| ser_ld_i | input | 1 | Word strobe; falling edge writes the word to a staging register |
| ser_upd_i | input | 1 | Update strobe; falling edge copies staging registers to outputs |
| dac_code_o | output | 32 | Four 8-bit output codes, channel 0 in the low byte |
| dac_gain_o | output | 4 | Gain flag per channel, 1 = x2 |
| frame_err_o | output | 1 | One-cycle pulse when a word of the wrong length is strobed |

## Verification
The hardest situations to reach from the ports are the coincidences: a word strobe falling in the very system clock in which the last serial bit also falls, and the two strobes falling together. The stimulus drives the lines on the falling system-clock edge and can therefore place two falling edges in one system clock at will; it then sends ten bits and lets the eleventh clash with the strobe, expecting an error and no write, and it strobes a new word and an update together, expecting the old value first and the new one only after a further update. A reset in the middle of a word confirms that the next full word is accepted without error.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   // Index of each serial line inside the edge-detector vector.
   typedef enum int unsigned {
      EV_SCLK = 0,
      EV_LOAD = 1,
      EV_UPD  = 2,
      EV_NUM  = 3
   } qdac_event_e;

   localparam int unsigned DEF_CHAN_BITS = 2;
   localparam int unsigned DEF_CODE_W    = 8;

   // Word length: channel field, one gain bit, code field.
   function automatic int unsigned frame_len(input int unsigned chan_bits,
                                             input int unsigned code_w);
      return chan_bits + 1 + code_w;
   endfunction

endpackage

// File: rtl/qdac_edge_det.sv
module qdac_edge_det #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] fall_o
);

   if (N < 1) begin : g_bad_n
      $error("qdac_edge_det: N must be at least 1");
   end

   logic [N-1:0] prev_q;

   for (genvar i = 0; i < N; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q[i] <= 1'b0;
         else        prev_q[i] <= lvl_i[i];
      end
      assign fall_o[i] = prev_q[i] & ~lvl_i[i];
   end

endmodule

// File: rtl/qdac_shift_rx.sv
module qdac_shift_rx #(
   parameter int unsigned FRAME_W = 11,
   parameter int unsigned CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_evt_i,
   input  logic               dat_i,
   input  logic               clr_evt_i,
   output logic [FRAME_W-1:0] word_o,
   output logic [CNT_W-1:0]   cnt_o
);

   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("qdac_shift_rx: FRAME_W must be at least 2");
   end
   if ((1 << CNT_W) <= (FRAME_W + 1)) begin : g_bad_cnt
      $error("qdac_shift_rx: CNT_W too small for FRAME_W + 1");
   end

   logic [FRAME_W-1:0] sr_q;
   logic [CNT_W-1:0]   cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (clr_evt_i) begin
         cnt_q <= '0;
      end else if (bit_evt_i) begin
         sr_q <= {sr_q[FRAME_W-2:0], dat_i};
         if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign word_o = sr_q;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
   parameter int unsigned CHAN_BITS = 2,
   parameter int unsigned CODE_W    = 8,
   localparam int unsigned NUM_CH   = 1 << CHAN_BITS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en_i,
   input  logic [CHAN_BITS-1:0]       wr_sel_i,
   input  logic                       wr_gain_i,
   input  logic [CODE_W-1:0]          wr_code_i,
   input  logic                       upd_en_i,
   output logic [NUM_CH*CODE_W-1:0]   stg_code_o,
   output logic [NUM_CH-1:0]          stg_gain_o,
   output logic [NUM_CH*CODE_W-1:0]   out_code_o,
   output logic [NUM_CH-1:0]          out_gain_o
);

   if (CHAN_BITS < 1) begin : g_bad_chan
      $error("qdac_chan_bank: CHAN_BITS must be at least 1");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("qdac_chan_bank: CODE_W must be at least 1");
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic [CODE_W-1:0] stg_code_q, out_code_q;
      logic              stg_gain_q, out_gain_q;
      logic              hit;

      assign hit = wr_en_i && (wr_sel_i == CHAN_BITS'(k));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stg_code_q <= '0;
            stg_gain_q <= 1'b0;
         end else if (hit) begin
            stg_code_q <= wr_code_i;
            stg_gain_q <= wr_gain_i;
         end
      end

      // Copies the staging value held before this edge.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_code_q <= '0;
            out_gain_q <= 1'b0;
         end else if (upd_en_i) begin
            out_code_q <= stg_code_q;
            out_gain_q <= stg_gain_q;
         end
      end

      assign stg_code_o[k*CODE_W +: CODE_W] = stg_code_q;
      assign stg_gain_o[k]                  = stg_gain_q;
      assign out_code_o[k*CODE_W +: CODE_W] = out_code_q;
      assign out_gain_o[k]                  = out_gain_q;
   end

endmodule

// File: rtl/qdac_serial_rx.sv
module qdac_serial_rx #(
   parameter int unsigned CHAN_BITS = qdac_pkg::DEF_CHAN_BITS,
   parameter int unsigned CODE_W    = qdac_pkg::DEF_CODE_W,
   localparam int unsigned NUM_CH   = 1 << CHAN_BITS,
   localparam int unsigned FRAME_W  = qdac_pkg::frame_len(CHAN_BITS, CODE_W),
   localparam int unsigned CNT_W    = $clog2(FRAME_W + 2)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_clk_i,
   input  logic                     ser_dat_i,
   input  logic                     ser_ld_i,
   input  logic                     ser_upd_i,
   output logic [NUM_CH*CODE_W-1:0] dac_code_o,
   output logic [NUM_CH-1:0]        dac_gain_o,
   output logic                     frame_err_o
);

   import qdac_pkg::*;

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic [EV_NUM-1:0]        lines, falls;
   logic                     sclk_fall, ld_fall, upd_fall;
   logic [FRAME_W-1:0]       word;
   logic [CNT_W-1:0]         bit_cnt;
   logic                     word_ok, wr_en;
   logic [CHAN_BITS-1:0]     wr_sel;
   logic                     wr_gain;
   logic [CODE_W-1:0]        wr_code;
   logic [NUM_CH*CODE_W-1:0] stg_code;
   logic [NUM_CH-1:0]        stg_gain;
   logic                     err_q;

   always_comb begin
      lines          = '0;
      lines[EV_SCLK] = ser_clk_i;
      lines[EV_LOAD] = ser_ld_i;
      lines[EV_UPD]  = ser_upd_i;
   end

   qdac_edge_det #(.N(EV_NUM)) u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (lines),
      .fall_o(falls)
   );

   assign sclk_fall = falls[EV_SCLK];
   assign ld_fall   = falls[EV_LOAD];
   assign upd_fall  = falls[EV_UPD];

   qdac_shift_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_evt_i(sclk_fall),
      .dat_i    (ser_dat_i),
      .clr_evt_i(ld_fall),
      .word_o   (word),
      .cnt_o    (bit_cnt)
   );

   // Word layout: channel on top, then gain, then code.
   assign wr_sel  = word[FRAME_W-1 -: CHAN_BITS];
   assign wr_gain = word[CODE_W];
   assign wr_code = word[CODE_W-1:0];
   assign word_ok = (bit_cnt == CNT_FULL);
   assign wr_en   = ld_fall && word_ok;

   qdac_chan_bank #(.CHAN_BITS(CHAN_BITS), .CODE_W(CODE_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_gain_i (wr_gain),
      .wr_code_i (wr_code),
      .upd_en_i  (upd_fall),
      .stg_code_o(stg_code),
      .stg_gain_o(stg_gain),
      .out_code_o(dac_code_o),
      .out_gain_o(dac_gain_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= ld_fall && !word_ok;
   end

   assign frame_err_o = err_q;

endmodule

// File: rtl/qdac_serial_rx_chk.sv
module qdac_serial_rx_chk #(
   parameter int unsigned CHAN_BITS = 2,
   parameter int unsigned CODE_W    = 8,
   localparam int unsigned NUM_CH   = 1 << CHAN_BITS,
   localparam int unsigned FRAME_W  = CHAN_BITS + 1 + CODE_W,
   localparam int unsigned CNT_W    = $clog2(FRAME_W + 2)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     sclk_fall,
   input logic                     ld_fall,
   input logic                     upd_fall,
   input logic [CNT_W-1:0]         bit_cnt,
   input logic [NUM_CH*CODE_W-1:0] stg_code,
   input logic [NUM_CH-1:0]        stg_gain,
   input logic [NUM_CH*CODE_W-1:0] dac_code_o,
   input logic [NUM_CH-1:0]        dac_gain_o,
   input logic                     frame_err_o
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] SAT  = CNT_W'(FRAME_W + 1);

   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_fall && !ld_fall && bit_cnt != SAT) |=> bit_cnt == $past(bit_cnt) + 1'b1);

   a_r3_good_word_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fall && bit_cnt == FULL) |=> !frame_err_o);

   a_r4_bad_word_err: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fall && bit_cnt != FULL) |=> frame_err_o && $stable(stg_code) && $stable(stg_gain));

   a_r4_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |=> !frame_err_o);

   a_r5_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fall |=> bit_cnt == '0);

   a_r6_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_fall |=> $stable(dac_code_o) && $stable(dac_gain_o));

   a_r7_update_old_stage: assert property (@(posedge clk) disable iff (!rst_n)
      upd_fall |=> dac_code_o == $past(stg_code) && dac_gain_o == $past(stg_gain));

endmodule

bind qdac_serial_rx qdac_serial_rx_chk #(.CHAN_BITS(CHAN_BITS), .CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sclk_fall  (sclk_fall),
   .ld_fall    (ld_fall),
   .upd_fall   (upd_fall),
   .bit_cnt    (bit_cnt),
   .stg_code   (stg_code),
   .stg_gain   (stg_gain),
   .dac_code_o (dac_code_o),
   .dac_gain_o (dac_gain_o),
   .frame_err_o(frame_err_o)
);

// File: tb/qdac_serial_rx_tb.sv
module qdac_serial_rx_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk_i = 1'b0, ser_dat_i = 1'b0, ser_ld_i = 1'b1, ser_upd_i = 1'b1;
   logic [31:0] dac_code_o;
   logic [3:0]  dac_gain_o;
   logic        frame_err_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] m_stg_code [4];
   logic       m_stg_gain [4];
   logic [7:0] m_out_code [4];
   logic       m_out_gain [4];

   always #2.5 clk = ~clk;

   qdac_serial_rx u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
      .ser_ld_i(ser_ld_i), .ser_upd_i(ser_upd_i), .dac_code_o(dac_code_o),
      .dac_gain_o(dac_gain_o), .frame_err_o(frame_err_o)
   );

   // Vector: [15:5] word, [4:1] bits sent, [0] update after load.
   localparam logic [15:0] VEC [8] = '{
      {2'b00, 1'b0, 8'h5A, 4'd11, 1'b0},
      {2'b01, 1'b1, 8'hC3, 4'd11, 1'b1},
      {2'b11, 1'b0, 8'hFF, 4'd11, 1'b0},
      {2'b10, 1'b1, 8'h01, 4'd11, 1'b1},
      {2'b00, 1'b1, 8'h80, 4'd7,  1'b1},
      {2'b01, 1'b0, 8'h00, 4'd13, 1'b1},
      {2'b11, 1'b1, 8'h7E, 4'd11, 1'b1},
      {2'b01, 1'b0, 8'h33, 4'd11, 1'b0}
   };

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_outs(input string req);
      logic [31:0] ec;
      logic [3:0]  eg;
      for (int k = 0; k < 4; k++) begin
         ec[k*8 +: 8] = m_out_code[k];
         eg[k]        = m_out_gain[k];
      end
      chk(dac_code_o === ec, req, "codes", dac_code_o, ec);
      chk(dac_gain_o === eg, req, "gains", {28'd0, dac_gain_o}, {28'd0, eg});
   endtask

   task automatic send_bits(input logic [10:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         ser_clk_i = 1'b1;
         ser_dat_i = (i < 11) ? w[10-i] : 1'b0;
         step();
         ser_clk_i = 1'b0;
         step();
      end
   endtask

   task automatic model_update();
      for (int k = 0; k < 4; k++) begin
         m_out_code[k] = m_stg_code[k];
         m_out_gain[k] = m_stg_gain[k];
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 4; k++) begin
         m_stg_code[k] = '0; m_stg_gain[k] = 1'b0;
         m_out_code[k] = '0; m_out_gain[k] = 1'b0;
      end
   endtask

   // Strobe the word line; error is visible right after the falling step.
   task automatic load_word(input logic exp_err, input string req);
      ser_ld_i = 1'b0;
      step();
      chk(frame_err_o === exp_err, req, "error pulse", {31'd0, frame_err_o}, {31'd0, exp_err});
      ser_ld_i = 1'b1;
      step();
      chk(frame_err_o === 1'b0, "R4", "error clears", {31'd0, frame_err_o}, 32'd0);
   endtask

   task automatic pulse_upd();
      ser_upd_i = 1'b0;
      step();
      model_update();
      ser_upd_i = 1'b1;
      step();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (4) step();
      // R8: reset state
      chk_outs("R8");
      chk(frame_err_o === 1'b0, "R8", "error in reset", {31'd0, frame_err_o}, 32'd0);
      rst_n = 1'b1;
      step(); step();
      chk_outs("R8");

      // Table walk: R1 R2 R3 R4 R6 R9 and staging invisibility (R6).
      for (int v = 0; v < 8; v++) begin
         logic [10:0] w;
         int          n;
         logic        ok;
         w  = VEC[v][15:5];
         n  = int'(VEC[v][4:1]);
         ok = (n == 11);
         send_bits(w, n);
         load_word(!ok, ok ? "R3" : "R4");
         if (ok) begin
            m_stg_code[w[10:9]] = w[7:0];
            m_stg_gain[w[10:9]] = w[8];
         end
         chk_outs("R6");
         if (VEC[v][0]) begin
            pulse_upd();
            chk_outs("R9");
         end
      end
      pulse_upd();
      chk_outs("R2");

      // R5: eleventh bit falls together with the word strobe -> dropped, error.
      send_bits({2'b10, 1'b0, 8'hA5}, 10);
      ser_clk_i = 1'b1; ser_dat_i = 1'b1;
      step();
      ser_clk_i = 1'b0; ser_ld_i = 1'b0;
      step();
      chk(frame_err_o === 1'b1, "R5", "coincident bit not counted", {31'd0, frame_err_o}, 32'd1);
      ser_ld_i = 1'b1;
      step();
      pulse_upd();
      chk_outs("R5");
      // R5: count restarted; a full word now loads cleanly.
      send_bits({2'b10, 1'b0, 8'hA5}, 11);
      load_word(1'b0, "R5");
      m_stg_code[2] = 8'hA5; m_stg_gain[2] = 1'b0;
      pulse_upd();
      chk_outs("R1");

      // R7: both strobes fall together -> outputs get old staging value.
      send_bits({2'b00, 1'b1, 8'h3C}, 11);
      ser_ld_i = 1'b0; ser_upd_i = 1'b0;
      step();
      model_update();
      m_stg_code[0] = 8'h3C; m_stg_gain[0] = 1'b1;
      chk(frame_err_o === 1'b0, "R7", "no error", {31'd0, frame_err_o}, 32'd0);
      chk_outs("R7");
      ser_ld_i = 1'b1; ser_upd_i = 1'b1;
      step();
      pulse_upd();
      chk_outs("R7");

      // R8: reset mid-word clears registers and the bit count.
      send_bits(11'h5F0, 6);
      rst_n = 1'b0;
      step(); step();
      model_reset();
      chk_outs("R8");
      rst_n = 1'b1;
      step();
      send_bits({2'b11, 1'b1, 8'h99}, 11);
      load_word(1'b0, "R8");
      m_stg_code[3] = 8'h99; m_stg_gain[3] = 1'b1;
      pulse_upd();
      chk_outs("R8");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule